// File: doc/BRIEF.md
# Sticky Per-Bit Fault Capture Register

This block gathers one-bit fault flags from a set of independent state machines that all drive their lines on every clock. Each bit position runs its own small life cycle. While a position is armed, a 1 on its input latches the output bit high and keeps it high for a downstream consumer. When the consumer acknowledges that position, the output bit drops back to 0 and the position is locked. From then on, further activity on that input line has no effect, even though the source keeps driving it.

Only a reset re-arms the positions. The reset is asynchronous and active-high, and it clears every output bit and every lock at once. Positions never interact: a capture, an acknowledge or a lock at one index leaves every other index unchanged.

Top module: `fault_capture_reg`

## Requirements
- R1: The number of positions is the parameter WIDTH (default 5). Bit i of `flag_q` depends only on bit i of `flag_in` and bit i of `ack_in`, so positions change independently of one another.
- R2: An armed position with `flag_in[i]`=1 and `ack_in[i]`=0 at a rising clock edge shows `flag_q[i]`=1 after that edge.
- R3: A set `flag_q[i]` stays 1 on every edge where `ack_in[i]` is 0, whatever value `flag_in[i]` takes.
- R4: `ack_in[i]`=1 at an edge where `flag_q[i]` is 1 makes `flag_q[i]` 0 after that edge.
- R5: Once a position has been acknowledged, `flag_in[i]`=1 never sets `flag_q[i]` again until reset.
- R6: `ack_in[i]`=1 on an armed position whose `flag_in[i]` is 0 has no effect: the output stays 0 and a later 1 on the input is still captured.
- R7: When `ack_in[i]`=1 and `flag_in[i]`=1 arrive at the same edge on an armed position, the input is dropped. `flag_q[i]` stays 0 and the position is locked.
- R8: `rst`=1 forces `flag_q` to all zeros at once, without waiting for a clock, and re-arms every position.
- R9: `ack_in[i]`=1 on a locked position has no effect, and `flag_q[i]` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| flag_in | input | WIDTH | Fault flags from the source state machines, one bit per position |
| ack_in | input | WIDTH | Per-position acknowledge from the consumer |
| flag_q | output | WIDTH | Captured fault flags |

## Verification
The properties assume that `flag_in` and `ack_in` are stable around each rising edge. They also assume that, after an asynchronous reset, the first edge they judge follows a cycle in which reset was sampled high. The stimulus meets both conditions. Inputs change only on the falling edge. Reset is raised between edges and held across at least one rising edge before it is released. Random phases acknowledge positions whether they are set, armed or locked, so acknowledges arrive in every state.

// File: rtl/fault_capture_pkg.sv
package fault_capture_pkg;

    typedef enum logic [1:0] {
        SLOT_ARMED  = 2'd0,
        SLOT_HELD   = 2'd1,
        SLOT_LOCKED = 2'd2
    } slot_state_e;

    typedef struct packed {
        logic raise;
        logic ack;
    } slot_req_t;

    function automatic slot_state_e slot_next(slot_state_e cur, slot_req_t req);
        slot_state_e nxt;
        nxt = cur;
        case (cur)
            SLOT_ARMED: begin
                if (req.raise && req.ack) nxt = SLOT_LOCKED;
                else if (req.raise)       nxt = SLOT_HELD;
            end
            SLOT_HELD: begin
                if (req.ack) nxt = SLOT_LOCKED;
            end
            default: nxt = SLOT_LOCKED;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/fault_slot.sv
module fault_slot
    import fault_capture_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  slot_req_t req,
    output logic      captured
);

    slot_state_e state_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= SLOT_ARMED;
        else     state_q <= slot_next(state_q, req);
    end

    assign captured = (state_q == SLOT_HELD);

endmodule

// File: rtl/fault_slot_bank.sv
module fault_slot_bank
    import fault_capture_pkg::*;
#(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raise_vec,
    input  logic [WIDTH-1:0] ack_vec,
    output logic [WIDTH-1:0] held_vec
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_slot
        slot_req_t req_g;
        assign req_g.raise = raise_vec[g];
        assign req_g.ack   = ack_vec[g];

        fault_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .req      (req_g),
            .captured (held_vec[g])
        );
    end

endmodule

// File: rtl/fault_capture_reg.sv
module fault_capture_reg #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] flag_in,
    input  logic [WIDTH-1:0] ack_in,
    output logic [WIDTH-1:0] flag_q
);

    fault_slot_bank #(.WIDTH(WIDTH)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .raise_vec (flag_in),
        .ack_vec   (ack_in),
        .held_vec  (flag_q)
    );

endmodule

// File: rtl/fault_capture_reg_chk.sv
module fault_capture_reg_chk #(
    parameter int WIDTH = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] flag_in,
    input logic [WIDTH-1:0] ack_in,
    input logic [WIDTH-1:0] flag_q
);

    logic [WIDTH-1:0] served_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) served_q <= '0;
        else     served_q <= served_q | (flag_q & ack_in);
    end

    // R2: a bit can only turn on when its input was 1 at that edge
    assert_rise_needs_input_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(flag_in)) == '0));

    // R3: a set bit without acknowledge stays set
    assert_hold_until_ack_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(flag_q & ~ack_in) & ~flag_q) == '0));

    // R4 and R7: any acknowledged position reads 0 after the edge
    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & $past(ack_in)) == '0));

    // R5: a serviced position never shows 1 again before reset
    assert_serviced_locked_R5: assert property (@(posedge clk) disable iff (rst)
        ((flag_q & served_q) == '0));

    // R8: reset released leaves all outputs clear
    assert_reset_clear_R8: assert property (@(posedge clk)
        $fell(rst) |-> (flag_q == '0));

endmodule

bind fault_capture_reg fault_capture_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .flag_in (flag_in),
    .ack_in  (ack_in),
    .flag_q  (flag_q)
);

// File: tb/fault_capture_reg_test.sv
module fault_capture_reg_test;

    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] flag_in = '0;
    logic [W-1:0] ack_in = '0;
    logic [W-1:0] flag_q;

    int compared   = 0;
    int mismatched = 0;
    int st [W];          // 0 armed, 1 held, 2 locked

    always #10 clk = ~clk;   // 50 MHz

    fault_capture_reg #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .flag_in(flag_in), .ack_in(ack_in), .flag_q(flag_q)
    );

    function automatic logic [W-1:0] model_out();
        logic [W-1:0] v;
        for (int i = 0; i < W; i++) v[i] = (st[i] == 1);
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < W; i++) st[i] = 0;
    endtask

    task automatic compare(string tag);
        logic [W-1:0] exp;
        exp = model_out();
        compared++;
        if (flag_q !== exp) begin
            mismatched++;
            $display("FAIL %s: flag_q got %b expected %b at %0t", tag, flag_q, exp, $time);
        end
    endtask

    // inputs set at falling edge, model advanced at rising edge, checked at next falling edge
    task automatic step(input logic [W-1:0] f, input logic [W-1:0] a, input string tag);
        flag_in = f;
        ack_in  = a;
        @(posedge clk);
        if (!rst) begin
            for (int i = 0; i < W; i++) begin
                if (st[i] == 0) begin
                    if (f[i] && a[i]) st[i] = 2;
                    else if (f[i])    st[i] = 1;
                end else if (st[i] == 1) begin
                    if (a[i]) st[i] = 2;
                end
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(200000 * 20);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        @(negedge clk);
        compare("R8 reset state");
        rst = 1'b0;

        step(5'b00001, 5'b00000, "R2 capture bit0");
        step(5'b00000, 5'b00000, "R3 hold after input falls");
        step(5'b00001, 5'b00000, "R3 hold with input high");
        step(5'b00000, 5'b00001, "R4 ack clears bit0");
        step(5'b00001, 5'b00000, "R5 locked bit0 ignores input");
        step(5'b11111, 5'b00000, "R5 locked bit0 with all inputs");
        // bits 1..4 now held; ack bit1, bit3
        step(5'b00000, 5'b01010, "R1 independent clear of bits 1 and 3");
        step(5'b01010, 5'b00000, "R5 bits 1 and 3 stay locked");
        step(5'b00000, 5'b00001, "R9 ack on locked bit0");

        // fresh reset between clock edges
        #3 rst = 1'b1;
        #1 model_reset();
        compare("R8 asynchronous clear");
        @(negedge clk);
        rst = 1'b0;

        step(5'b00000, 5'b00100, "R6 ack on armed idle bit2");
        step(5'b00100, 5'b00000, "R6 bit2 still captures");
        step(5'b00010, 5'b00010, "R7 simultaneous input and ack bit1");
        step(5'b00010, 5'b00000, "R7 bit1 locked");
        step(5'b00011, 5'b00000, "R8 reset re-armed bit0");
        step(5'b10000, 5'b00000, "R1 bit4 alone");

        for (int n = 0; n < 600; n++) begin
            if (n % 80 == 79) begin
                rst = 1'b1;
                model_reset();
                @(negedge clk);
                compare("R8 periodic reset");
                rst = 1'b0;
            end else begin
                step(W'($urandom), W'($urandom & $urandom), "R2 random traffic");
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule